// File: doc/BRIEF.md
# Remote-Update Parameter Access Port

This block is the front end through which user logic reads and writes the parameters of a remote-update controller. A read or write is requested with a single-cycle pulse together with a 3-bit slot selector. When the block samples that pulse, it raises `busy` on the same clock edge. `busy` then stays high for a fixed number of cycles, which stands for the time the parameter needs to be shifted serially into or out of the controller. The shift chain itself is not modelled; the parameters live in a small bank of slots that keep only as many low-order bits as each parameter needs.

Writes are honoured only while the device runs its factory image (`factory_mode` high). In application mode a write request and its data are dropped. Reads work in both modes. A reconfiguration request is passed on as a one-cycle `reconfig_go` pulse, but only when no access is in progress.

Top module: `rupd_param_port`

## Requirements
- R1: While `rst` is high and after it is released, `busy`, `reconfig_go` and `rdata` are 0, and every parameter slot reads back as 0.
- R2: A request sampled while idle raises `busy` on that same clock edge, and `busy` stays high for exactly ACCESS_CYCLES cycles (8 by default).
- R3: When `busy` falls after a read, `rdata` holds the value of the slot that `sel` named when the read was sampled. `rdata` does not change while `busy` is high.
- R4: A read or write request that arrives while `busy` is high is ignored. It does not lengthen `busy` and does not change any slot or `rdata`.
- R5: With `factory_mode` low, a write request is ignored: `busy` stays low and the slot keeps its value. Reads still work in this mode.
- R6: The slot widths in bits are: sel 0 = 5, 1 = 1, 2 = 12, 3 = 2, 4 = 32, 5 = 1, 6 = 12, 7 = 32. A write keeps `wdata[W-1:0]`, and a read returns the stored value in the low W bits with all upper bits zero.
- R7: When `reconfig_req` is sampled high while `busy` is low, `reconfig_go` is 1 for the following cycle. A `reconfig_req` sampled while `busy` is high produces no pulse.
- R8: If `rd_req` and `wr_req` are both sampled high while idle, the read is performed and the write is dropped.
- R9: A write stores the `wdata` present on the edge that accepted the request. Later changes to `wdata` while `busy` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset. Its release is synchronised inside the block. |
| rd_req | input | 1 | Read request, one-cycle pulse |
| wr_req | input | 1 | Write request, one-cycle pulse |
| sel | input | 3 | Parameter slot selector |
| wdata | input | 32 | Write data; only the low bits of narrow slots are used |
| reconfig_req | input | 1 | Reconfiguration request |
| factory_mode | input | 1 | High while the factory image runs; writes are allowed only then |
| rdata | output | 32 | Read result, valid once `busy` is low |
| busy | output | 1 | An access is in progress |
| reconfig_go | output | 1 | Forwarded reconfiguration pulse |

## Verification
The assertions assume that requests are single-cycle pulses and that `factory_mode` does not change in the middle of an access. They also assume at least two clock edges pass after `rst` falls before the first request, so the synchronised reset release has completed. The stimulus drives every input on the falling edge and returns each request to 0 on the next falling edge. It changes `factory_mode` only while the block is idle, and it waits several cycles after reset before issuing any request. Deliberate requests during `busy` and changes to `wdata` during `busy` stay within these assumptions, because the block must tolerate them.

// File: rtl/rupd_pkg.sv
package rupd_pkg;

  localparam int DEF_SEL_W  = 3;
  localparam int DEF_DATA_W = 32;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Number of significant low-order bits kept for each parameter slot.
  function automatic int slot_width(input int idx, input int data_w);
    int w;
    case (idx)
      0:       w = 5;
      1:       w = 1;
      2:       w = 12;
      3:       w = 2;
      4:       w = 32;
      5:       w = 1;
      6:       w = 12;
      default: w = 32;
    endcase
    if (w > data_w) w = data_w;
    return w;
  endfunction

endpackage

// File: rtl/rupd_rst_sync.sv
module rupd_rst_sync (
  input  logic clk,
  input  logic rst_async,
  output logic rst_n_sync
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or posedge rst_async) begin
    if (rst_async) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;

endmodule

// File: rtl/rupd_seq.sv
module rupd_seq
  import rupd_pkg::*;
#(
  parameter int ACCESS_CYCLES = 8,
  parameter int SEL_W         = DEF_SEL_W,
  parameter int DATA_W        = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic              factory_mode,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              rd_done,
  output logic              wr_done,
  output logic [SEL_W-1:0]  sel_hold,
  output logic [DATA_W-1:0] data_hold
);

  localparam int CNT_W = (ACCESS_CYCLES > 1) ? $clog2(ACCESS_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACCESS_CYCLES - 1);

  op_e               state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cap_en;
  logic              cap_data_en;
  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] data_q;

  // Next-state logic
  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    cap_en      = 1'b0;
    cap_data_en = 1'b0;
    rd_done     = 1'b0;
    wr_done     = 1'b0;
    case (state_q)
      OP_IDLE: begin
        if (rd_req) begin
          state_d = OP_READ;
          cnt_d   = CNT_LAST;
          cap_en  = 1'b1;
        end else if (wr_req && factory_mode) begin
          state_d     = OP_WRITE;
          cnt_d       = CNT_LAST;
          cap_en      = 1'b1;
          cap_data_en = 1'b1;
        end
      end
      OP_READ, OP_WRITE: begin
        if (cnt_q == '0) begin
          state_d = OP_IDLE;
          rd_done = (state_q == OP_READ);
          wr_done = (state_q == OP_WRITE);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        state_d = OP_IDLE;
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= OP_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // Operand capture with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (cap_en) begin
      sel_q <= sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (cap_data_en) begin
      data_q <= wdata;
    end
  end

  assign busy      = (state_q != OP_IDLE);
  assign sel_hold  = sel_q;
  assign data_hold = data_q;

endmodule

// File: rtl/rupd_params.sv
module rupd_params
  import rupd_pkg::*;
#(
  parameter int SEL_W  = DEF_SEL_W,
  parameter int DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_value
);

  localparam int SLOTS = 1 << SEL_W;

  logic [DATA_W-1:0] slot_view [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    localparam int W = slot_width(g, DATA_W);
    logic [W-1:0]      slot_q;
    logic              slot_we;
    logic [DATA_W-1:0] slot_ext;

    assign slot_we = wr_en && (wr_sel == SEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (slot_we) begin
        slot_q <= wr_data[W-1:0];
      end
    end

    always_comb begin
      slot_ext        = '0;
      slot_ext[W-1:0] = slot_q;
    end

    assign slot_view[g] = slot_ext;
  end

  assign rd_value = slot_view[rd_sel];

endmodule

// File: rtl/rupd_param_port.sv
module rupd_param_port
  import rupd_pkg::*;
#(
  parameter int ACCESS_CYCLES = 8,
  parameter int SEL_W         = DEF_SEL_W,
  parameter int DATA_W        = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              reconfig_req,
  input  logic              factory_mode,
  output logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic              reconfig_go
);

  logic              rst_n_sync;
  logic              seq_busy;
  logic              rd_done;
  logic              wr_done;
  logic [SEL_W-1:0]  sel_hold;
  logic [DATA_W-1:0] data_hold;
  logic [DATA_W-1:0] slot_value;

  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              go_q, go_d;

  rupd_rst_sync u_rst (
    .clk        (clk),
    .rst_async  (rst),
    .rst_n_sync (rst_n_sync)
  );

  rupd_seq #(
    .ACCESS_CYCLES (ACCESS_CYCLES),
    .SEL_W         (SEL_W),
    .DATA_W        (DATA_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .rd_req       (rd_req),
    .wr_req       (wr_req),
    .factory_mode (factory_mode),
    .sel          (sel),
    .wdata        (wdata),
    .busy         (seq_busy),
    .rd_done      (rd_done),
    .wr_done      (wr_done),
    .sel_hold     (sel_hold),
    .data_hold    (data_hold)
  );

  rupd_params #(
    .SEL_W  (SEL_W),
    .DATA_W (DATA_W)
  ) u_params (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .wr_en    (wr_done),
    .wr_sel   (sel_hold),
    .wr_data  (data_hold),
    .rd_sel   (sel_hold),
    .rd_value (slot_value)
  );

  // Next values for output registers
  always_comb begin
    rdata_d = rdata_q;
    if (rd_done) rdata_d = slot_value;
    go_d = reconfig_req && !seq_busy;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      rdata_q <= '0;
      go_q    <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      go_q    <= go_d;
    end
  end

  assign rdata       = rdata_q;
  assign busy        = seq_busy;
  assign reconfig_go = go_q;

endmodule

// File: rtl/rupd_param_port_chk.sv
module rupd_param_port_chk #(
  parameter int ACCESS_CYCLES = 8,
  parameter int DATA_W        = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic              wr_req,
  input logic              factory_mode,
  input logic              busy,
  input logic              reconfig_go,
  input logic [DATA_W-1:0] rdata
);

  logic [15:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (busy) run_q <= run_q + 16'd1;
    else run_q <= '0;
  end

  AST_READ_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !busy) |=> busy); // R2

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == 16'(ACCESS_CYCLES))); // R2

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(rdata)); // R3

  AST_APP_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !rd_req && !factory_mode && !busy) |=> !busy); // R5

  AST_NO_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !reconfig_go); // R7

  AST_BUSY_NOT_EXTENDED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run_q == 16'(ACCESS_CYCLES - 1)) |=> !busy); // R4

endmodule

bind rupd_param_port rupd_param_port_chk #(
  .ACCESS_CYCLES (ACCESS_CYCLES),
  .DATA_W        (DATA_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n_sync),
  .rd_req       (rd_req),
  .wr_req       (wr_req),
  .factory_mode (factory_mode),
  .busy         (busy),
  .reconfig_go  (reconfig_go),
  .rdata        (rdata)
);

// File: tb/tb_rupd_param_port.sv
module tb_rupd_param_port;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_req = 1'b0;
  logic        wr_req = 1'b0;
  logic [2:0]  sel = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic        reconfig_req = 1'b0;
  logic        factory_mode = 1'b1;
  logic [31:0] rdata;
  logic        busy;
  logic        reconfig_go;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rupd_param_port #(.ACCESS_CYCLES(N)) dut (
    .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req), .sel(sel),
    .wdata(wdata), .reconfig_req(reconfig_req), .factory_mode(factory_mode),
    .rdata(rdata), .busy(busy), .reconfig_go(reconfig_go)
  );

  function automatic logic [31:0] mask_of(input int s);
    case (s)
      0: return 32'h0000_001F;
      1: return 32'h0000_0001;
      2: return 32'h0000_0FFF;
      3: return 32'h0000_0003;
      5: return 32'h0000_0001;
      6: return 32'h0000_0FFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // Behavioural reference model
  logic [31:0] m_regs [8];
  logic [31:0] m_rdata;
  logic [31:0] m_data;
  logic        m_busy, m_go, m_is_read;
  int          m_left;
  int          m_sel;

  always @(posedge clk or posedge rst) begin
    if (rst) begin
      m_busy = 0; m_go = 0; m_rdata = 0; m_left = 0; m_sel = 0;
      m_data = 0; m_is_read = 0;
      for (int i = 0; i < 8; i++) m_regs[i] = 0;
    end else begin
      m_go = reconfig_req && !m_busy;
      if (m_busy) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          if (m_is_read) m_rdata = m_regs[m_sel];
          else m_regs[m_sel] = m_data & mask_of(m_sel);
          m_busy = 0;
        end
      end else if (rd_req) begin
        m_busy = 1; m_left = N; m_is_read = 1; m_sel = int'(sel);
      end else if (wr_req && factory_mode) begin
        m_busy = 1; m_left = N; m_is_read = 0; m_sel = int'(sel); m_data = wdata;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk("R2 busy vs model", {31'd0, busy}, {31'd0, m_busy});
      chk("R3 rdata vs model", rdata, m_rdata);
      chk("R7 reconfig_go vs model", {31'd0, reconfig_go}, {31'd0, m_go});
    end
    if (cycles > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic pulse_rd(input int s);
    @(negedge clk); rd_req = 1; sel = 3'(s);
    @(negedge clk); rd_req = 0;
  endtask

  task automatic pulse_wr(input int s, input logic [31:0] d);
    @(negedge clk); wr_req = 1; sel = 3'(s); wdata = d;
    @(negedge clk); wr_req = 0;
  endtask

  task automatic settle();
    repeat (N) @(negedge clk);
  endtask

  task automatic read_expect(input string tag, input int s, input logic [31:0] exp);
    pulse_rd(s); settle();
    chk(tag, rdata, exp);
  endtask

  initial begin
    int blen;
    logic [31:0] prev;
    repeat (3) @(negedge clk);
    chk("R1 busy under reset", {31'd0, busy}, 32'd0);
    rst = 0;
    repeat (5) @(negedge clk);
    chk("R1 busy after reset", {31'd0, busy}, 32'd0);
    chk("R1 rdata after reset", rdata, 32'd0);
    chk("R1 reconfig_go after reset", {31'd0, reconfig_go}, 32'd0);
    read_expect("R1 slot4 zero", 4, 32'd0);

    // R2: busy length
    @(negedge clk); wr_req = 1; sel = 3'd4; wdata = 32'hA5A5_1234;
    @(negedge clk); wr_req = 0;
    chk("R2 busy rises", {31'd0, busy}, 32'd1);
    blen = 0;
    while (busy && blen < 100) begin blen++; @(negedge clk); end
    chk("R2 busy cycles", 32'(blen), 32'(N));
    read_expect("R3 slot4 readback", 4, 32'hA5A5_1234);

    // R6: widths
    for (int s = 0; s < 8; s++) begin pulse_wr(s, 32'hFFFF_FFFF); settle(); end
    for (int s = 0; s < 8; s++) read_expect("R6 slot width", s, mask_of(s));

    // R5: application mode write ignored
    factory_mode = 0;
    @(negedge clk); wr_req = 1; sel = 3'd2; wdata = 32'h0;
    @(negedge clk); wr_req = 0;
    chk("R5 no busy in app mode", {31'd0, busy}, 32'd0);
    read_expect("R5 slot2 unchanged", 2, 32'h0000_0FFF);
    factory_mode = 1;

    // R4: requests during busy ignored
    pulse_rd(0);
    @(negedge clk); wr_req = 1; sel = 3'd0; wdata = 32'd3;
    @(negedge clk); wr_req = 0; rd_req = 1; sel = 3'd5;
    @(negedge clk); rd_req = 0;
    repeat (N - 3) @(negedge clk);
    chk("R4 busy not extended", {31'd0, busy}, 32'd0);
    chk("R4 rdata from first read", rdata, 32'h0000_001F);
    read_expect("R4 slot0 unchanged", 0, 32'h0000_001F);

    // R9: wdata changed during busy
    pulse_wr(6, 32'h0000_0123);
    wdata = 32'h0000_0ABC;
    settle();
    read_expect("R9 captured wdata", 6, 32'h0000_0123);

    // R8: read priority
    @(negedge clk); rd_req = 1; wr_req = 1; sel = 3'd7; wdata = 32'h0;
    @(negedge clk); rd_req = 0; wr_req = 0;
    settle();
    chk("R8 read served", rdata, 32'hFFFF_FFFF);
    read_expect("R8 write dropped", 7, 32'hFFFF_FFFF);

    // R3: rdata holds while busy
    pulse_rd(3);
    prev = rdata;
    for (int k = 0; k < N - 1; k++) begin
      chk("R3 rdata stable while busy", rdata, prev);
      @(negedge clk);
    end
    @(negedge clk);
    chk("R3 rdata slot3", rdata, 32'h0000_0003);

    // R7: reconfig forwarding
    @(negedge clk); reconfig_req = 1;
    @(negedge clk); reconfig_req = 0;
    chk("R7 go when idle", {31'd0, reconfig_go}, 32'd1);
    @(negedge clk);
    chk("R7 go one cycle", {31'd0, reconfig_go}, 32'd0);
    pulse_rd(1);
    reconfig_req = 1;
    @(negedge clk); reconfig_req = 0;
    chk("R7 no go while busy", {31'd0, reconfig_go}, 32'd0);
    settle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule